// File: doc/BRIEF.md
# Calendar init and sync controller

This block sits between a bus-clocked register port and a calendar that counts on a slow RTC clock. Software uses it to stop the calendar, load new time, date, divider and hour-format settings, and let counting resume. Before anything is written, an init request set by software must cross into the RTC domain and an acknowledge must come back. Writes to the calendar settings are honoured only while both are present.

The block also keeps bus-side shadow copies of the running time and date. Software asks for a fresh copy by clearing a "synchronised" flag. The RTC side captures the calendar and hands the capture back, and the flag then rises again. A "calendar valid" status bit is derived from the year byte of the shadow date. A two-stage divider in the RTC domain produces the once-per-second tick that the calendar counts. That divider is cleared and held while init mode is active. When init mode ends and new time or date values were written, a one-cycle load strobe tells the calendar to take them.

Top module: `calsync_ctrl`

## Requirements
- R1: Register map on `addr`: 0 control (bit0 init request, bit1 12-hour format), 1 status (bit0 init acknowledge, bit1 synchronised flag, bit2 calendar valid), 2 divider, 3 time, 4 date. The init acknowledge reads 0 right after the request is written. It reads 1 within 4 RTC cycles plus 3 bus cycles, and returns to 0 after the request is cleared.
- R2: `cal_hold` rises after the init request crosses into the RTC domain and falls after it is cleared. `cal_tick` is never high in the RTC cycle after one in which `cal_hold` was high.
- R3: Writes to time, date, divider and the format bit take effect only while the init request and the init acknowledge are both 1. At any other time they leave `cal_set_time`, `cal_set_date`, `cal_fmt12` and the divider readback unchanged.
- R4: The divider register holds the synchronous field in bits 14:0 and the asynchronous field in bits 22:16. It reads back exactly what was written, including a first write carrying only the synchronous field. After reset it reads 0x007F00FF.
- R5: After `cal_hold` falls, the first `cal_tick` comes (A+1)*(S+1) RTC cycles later, and later ticks come at that same spacing. A is the asynchronous field and S is the synchronous field.
- R6: `cal_load` pulses for exactly one RTC cycle, in the cycle `cal_hold` falls, if time or date was written during that init session. It stays low otherwise.
- R7: Writing 0 to status bit1 while it is 1 clears the synchronised flag at once. The flag returns to 1 once the time and date shadows hold a fresh capture of `cal_time`/`cal_date`. Writing 1 to the bit has no effect and triggers no refresh.
- R8: After reset, the synchronised flag comes up by itself once the first capture has been transferred.
- R9: Calendar valid (status bit2) is 1 exactly when the year byte, bits 31:24 of the shadow date, is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-domain asynchronous reset, active low |
| rtc_clk | input | 1 | Slow calendar clock |
| rtc_rst_n | input | 1 | RTC-domain asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| cal_time | input | 24 | Live calendar time (RTC domain) |
| cal_date | input | 32 | Live calendar date, year in bits 31:24 (RTC domain) |
| cal_set_time | output | 24 | Time value to load into the calendar |
| cal_set_date | output | 32 | Date value to load into the calendar |
| cal_fmt12 | output | 1 | 1 selects 12-hour mode, 0 selects 24-hour mode |
| cal_hold | output | 1 | Calendar hold (RTC domain) |
| cal_tick | output | 1 | One-second tick, one RTC cycle wide |
| cal_load | output | 1 | Load strobe for the new time and date (RTC domain) |

## Verification
Two events can meet in one RTC cycle: the divider reaching its terminal count and the hold arriving from an init request. The bench provokes this by issuing the init request at several phase offsets after a tick, so that the hold lands on different divider states, one of them the wrap. It then requires that no tick appears while held, and that a full, fresh (A+1)*(S+1) period follows the release. A second coincidence is the load strobe with the hold release; the bench judges it at the exact RTC cycle in which the hold is first seen low.

// File: rtl/calsync_pkg.sv
`timescale 1ns/1ps
package calsync_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 3'd0,
        REG_STAT  = 3'd1,
        REG_PRESC = 3'd2,
        REG_TIME  = 3'd3,
        REG_DATE  = 3'd4
    } reg_addr_e;

    localparam int CTRL_INIT_BIT   = 0;
    localparam int CTRL_FMT_BIT    = 1;
    localparam int STAT_ACK_BIT    = 0;
    localparam int STAT_SYNC_BIT   = 1;
    localparam int STAT_VALID_BIT  = 2;
    localparam int PRESC_ASYNC_LSB = 16;
endpackage

// File: rtl/calsync_sync2.sv
`timescale 1ns/1ps
module calsync_sync2 #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] sync_q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end
endmodule

// File: rtl/calsync_prescaler.sv
`timescale 1ns/1ps
module calsync_prescaler #(
    parameter int ASYNC_W = 7,
    parameter int SYNC_W  = 15
) (
    input  logic               rtc_clk,
    input  logic               rtc_rst_n,
    input  logic               hold,
    input  logic [ASYNC_W-1:0] div_a,
    input  logic [SYNC_W-1:0]  div_s,
    output logic               tick
);
    typedef struct packed {
        logic [ASYNC_W-1:0] a_cnt;
        logic [SYNC_W-1:0]  s_cnt;
        logic               tick;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (hold) begin
            st_d.a_cnt = '0;
            st_d.s_cnt = '0;
        end else if (st_q.a_cnt >= div_a) begin
            st_d.a_cnt = '0;
            if (st_q.s_cnt >= div_s) begin
                st_d.s_cnt = '0;
                st_d.tick  = 1'b1;
            end else begin
                st_d.s_cnt = st_q.s_cnt + 1'b1;
            end
        end else begin
            st_d.a_cnt = st_q.a_cnt + 1'b1;
        end
    end

    always_ff @(posedge rtc_clk or negedge rtc_rst_n) begin
        if (!rtc_rst_n) st_q <= '0;
        else            st_q <= st_d;
    end

    assign tick = st_q.tick;
endmodule

// File: rtl/calsync_rtc_side.sv
`timescale 1ns/1ps
module calsync_rtc_side #(
    parameter int TIME_W  = 24,
    parameter int DATE_W  = 32,
    parameter int ASYNC_W = 7,
    parameter int SYNC_W  = 15
) (
    input  logic               rtc_clk,
    input  logic               rtc_rst_n,
    input  logic               init_req,
    input  logic               refresh_tgl,
    input  logic               dirty,
    input  logic [ASYNC_W-1:0] div_a,
    input  logic [SYNC_W-1:0]  div_s,
    input  logic [TIME_W-1:0]  cal_time,
    input  logic [DATE_W-1:0]  cal_date,
    output logic               hold,
    output logic               tick,
    output logic               load,
    output logic               refresh_ack,
    output logic [TIME_W-1:0]  snap_time,
    output logic [DATE_W-1:0]  snap_date
);
    typedef struct packed {
        logic              hold;
        logic              load;
        logic              ack_tgl;
        logic [TIME_W-1:0] snap_time;
        logic [DATE_W-1:0] snap_date;
    } rtc_st_t;

    rtc_st_t st_d, st_q;
    logic    req_s, tgl_s;

    calsync_sync2 #(.W(2), .RST_VAL(2'b00)) u_in_sync (
        .clk    (rtc_clk),
        .rst_n  (rtc_rst_n),
        .d      ({refresh_tgl, init_req}),
        .sync_q ({tgl_s, req_s})
    );

    always_comb begin
        st_d      = st_q;
        st_d.hold = req_s;
        // strobe only on the release edge, and only for a session with new values
        st_d.load = st_q.hold & ~req_s & dirty;
        if (tgl_s != st_q.ack_tgl) begin
            st_d.ack_tgl   = tgl_s;
            st_d.snap_time = cal_time;
            st_d.snap_date = cal_date;
        end
    end

    always_ff @(posedge rtc_clk or negedge rtc_rst_n) begin
        if (!rtc_rst_n) st_q <= '0;
        else            st_q <= st_d;
    end

    calsync_prescaler #(.ASYNC_W(ASYNC_W), .SYNC_W(SYNC_W)) u_div (
        .rtc_clk   (rtc_clk),
        .rtc_rst_n (rtc_rst_n),
        .hold      (st_q.hold),
        .div_a     (div_a),
        .div_s     (div_s),
        .tick      (tick)
    );

    assign hold        = st_q.hold;
    assign load        = st_q.load;
    assign refresh_ack = st_q.ack_tgl;
    assign snap_time   = st_q.snap_time;
    assign snap_date   = st_q.snap_date;
endmodule

// File: rtl/calsync_ctrl.sv
`timescale 1ns/1ps
module calsync_ctrl
    import calsync_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int TIME_W    = 24,
    parameter int DATE_W    = 32,
    parameter int ASYNC_W   = 7,
    parameter int SYNC_W    = 15,
    parameter int ASYNC_RST = 127,
    parameter int SYNC_RST  = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rtc_clk,
    input  logic              rtc_rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [TIME_W-1:0] cal_time,
    input  logic [DATE_W-1:0] cal_date,
    output logic [TIME_W-1:0] cal_set_time,
    output logic [DATE_W-1:0] cal_set_date,
    output logic              cal_fmt12,
    output logic              cal_hold,
    output logic              cal_tick,
    output logic              cal_load
);
    localparam int YEAR_W   = 8;
    localparam int YEAR_LSB = DATE_W - YEAR_W;

    typedef struct packed {
        logic               init_req;
        logic               fmt12;
        logic [SYNC_W-1:0]  div_s;
        logic [ASYNC_W-1:0] div_a;
        logic [TIME_W-1:0]  set_time;
        logic [DATE_W-1:0]  set_date;
        logic [TIME_W-1:0]  shd_time;
        logic [DATE_W-1:0]  shd_date;
        logic               synced;
        logic               refresh_tgl;
        logic               dirty;
    } bus_st_t;

    bus_st_t            st_d, st_q;
    logic               ack_s, refresh_ack_s, write_ok;
    logic               hold_rtc, refresh_ack_rtc;
    logic [TIME_W-1:0]  snap_time;
    logic [DATE_W-1:0]  snap_date;
    logic               init_req_w, synced_w;

    calsync_sync2 #(.W(2), .RST_VAL(2'b00)) u_bus_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      ({refresh_ack_rtc, hold_rtc}),
        .sync_q ({refresh_ack_s, ack_s})
    );

    assign init_req_w = st_q.init_req;
    assign synced_w   = st_q.synced;
    assign write_ok   = init_req_w & ack_s;

    always_comb begin
        st_d = st_q;
        if (!ack_s) st_d.dirty = 1'b0;
        if (!st_q.synced && (refresh_ack_s == st_q.refresh_tgl)) begin
            st_d.shd_time = snap_time;
            st_d.shd_date = snap_date;
            st_d.synced   = 1'b1;
        end
        if (wr_en) begin
            case (addr)
                REG_CTRL: begin
                    st_d.init_req = wdata[CTRL_INIT_BIT];
                    if (write_ok) st_d.fmt12 = wdata[CTRL_FMT_BIT];
                end
                REG_STAT: begin
                    if (!wdata[STAT_SYNC_BIT] && st_q.synced) begin
                        st_d.synced      = 1'b0;
                        st_d.refresh_tgl = ~st_q.refresh_tgl;
                    end
                end
                REG_PRESC: begin
                    if (write_ok) begin
                        st_d.div_s = wdata[SYNC_W-1:0];
                        st_d.div_a = wdata[PRESC_ASYNC_LSB +: ASYNC_W];
                    end
                end
                REG_TIME: begin
                    if (write_ok) begin
                        st_d.set_time = wdata[TIME_W-1:0];
                        st_d.dirty    = 1'b1;
                    end
                end
                REG_DATE: begin
                    if (write_ok) begin
                        st_d.set_date = wdata[DATE_W-1:0];
                        st_d.dirty    = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q             <= '0;
            st_q.div_a       <= ASYNC_W'(ASYNC_RST);
            st_q.div_s       <= SYNC_W'(SYNC_RST);
            st_q.refresh_tgl <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            REG_CTRL: begin
                rdata[CTRL_INIT_BIT] = init_req_w;
                rdata[CTRL_FMT_BIT]  = st_q.fmt12;
            end
            REG_STAT: begin
                rdata[STAT_ACK_BIT]   = ack_s;
                rdata[STAT_SYNC_BIT]  = synced_w;
                rdata[STAT_VALID_BIT] = |st_q.shd_date[YEAR_LSB +: YEAR_W];
            end
            REG_PRESC: begin
                rdata[SYNC_W-1:0]                  = st_q.div_s;
                rdata[PRESC_ASYNC_LSB +: ASYNC_W]  = st_q.div_a;
            end
            REG_TIME: rdata[TIME_W-1:0] = st_q.shd_time;
            REG_DATE: rdata[DATE_W-1:0] = st_q.shd_date;
            default:  ;
        endcase
    end

    calsync_rtc_side #(
        .TIME_W(TIME_W), .DATE_W(DATE_W), .ASYNC_W(ASYNC_W), .SYNC_W(SYNC_W)
    ) u_rtc (
        .rtc_clk     (rtc_clk),
        .rtc_rst_n   (rtc_rst_n),
        .init_req    (init_req_w),
        .refresh_tgl (st_q.refresh_tgl),
        .dirty       (st_q.dirty),
        .div_a       (st_q.div_a),
        .div_s       (st_q.div_s),
        .cal_time    (cal_time),
        .cal_date    (cal_date),
        .hold        (hold_rtc),
        .tick        (cal_tick),
        .load        (cal_load),
        .refresh_ack (refresh_ack_rtc),
        .snap_time   (snap_time),
        .snap_date   (snap_date)
    );

    assign cal_hold     = hold_rtc;
    assign cal_set_time = st_q.set_time;
    assign cal_set_date = st_q.set_date;
    assign cal_fmt12    = st_q.fmt12;
endmodule

// File: rtl/calsync_chk.sv
`timescale 1ns/1ps
module calsync_chk #(
    parameter int DATA_W = 32,
    parameter int TIME_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rtc_clk,
    input logic              rtc_rst_n,
    input logic              wr_en,
    input logic [2:0]        addr,
    input logic [DATA_W-1:0] wdata,
    input logic              init_req,
    input logic              initf,
    input logic              synced,
    input logic [TIME_W-1:0] cal_set_time,
    input logic              cal_hold,
    input logic              cal_tick,
    input logic              cal_load
);
    // R3
    set_time_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cal_set_time) |-> $past(wr_en && init_req && initf));

    // R7
    sync_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(synced) |-> $past(wr_en && addr == 3'd1 && !wdata[1]));

    // R2
    no_tick_in_hold_chk: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
        cal_hold |=> !cal_tick);

    // R6
    load_on_release_chk: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
        cal_load |-> ($past(cal_hold) && !cal_hold));

    // R6
    load_one_cycle_chk: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
        cal_load |=> !cal_load);
endmodule

bind calsync_ctrl calsync_chk #(.DATA_W(DATA_W), .TIME_W(TIME_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rtc_clk      (rtc_clk),
    .rtc_rst_n    (rtc_rst_n),
    .wr_en        (wr_en),
    .addr         (addr),
    .wdata        (wdata),
    .init_req     (init_req_w),
    .initf        (ack_s),
    .synced       (synced_w),
    .cal_set_time (cal_set_time),
    .cal_hold     (cal_hold),
    .cal_tick     (cal_tick),
    .cal_load     (cal_load)
);

// File: tb/sim_calsync_ctrl.sv
`timescale 1ns/1ps
module sim_calsync_ctrl;
    logic        clk = 1'b0, rtc_clk = 1'b0;
    logic        rst_n = 1'b0, rtc_rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0, rdata;
    logic [23:0] cal_time = '0, cal_set_time;
    logic [31:0] cal_date = '0, cal_set_date;
    logic        cal_fmt12, cal_hold, cal_tick, cal_load;
    int          n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;
    always #20  rtc_clk = ~rtc_clk;

    calsync_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .rtc_clk(rtc_clk), .rtc_rst_n(rtc_rst_n),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .cal_time(cal_time), .cal_date(cal_date),
        .cal_set_time(cal_set_time), .cal_set_date(cal_set_date),
        .cal_fmt12(cal_fmt12), .cal_hold(cal_hold), .cal_tick(cal_tick),
        .cal_load(cal_load)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic poll_stat(input int idx, input logic val, output int n);
        logic [31:0] d;
        n = 0;
        for (int i = 0; i < 300; i++) begin
            bus_rd(3'd1, d);
            n = i;
            if (d[idx] == val) break;
        end
    endtask

    task automatic wait_hold(input logic v);
        for (int i = 0; i < 100; i++) begin
            @(negedge rtc_clk);
            if (cal_hold == v) break;
        end
    endtask

    task automatic ticks_until(output int n);
        n = 0;
        for (int i = 1; i < 60; i++) begin
            @(negedge rtc_clk);
            n = i;
            if (cal_tick) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        int n;
        bus_rd(3'd0, d);           chk("R1 control after reset", d, 32'h0);
        chk("R2 hold after reset", {31'd0, cal_hold}, 32'd0);
        bus_rd(3'd2, d);           chk("R4 divider reset value", d, 32'h007F00FF);
        poll_stat(1, 1'b1, n);
        bus_rd(3'd1, d);           chk("R8 sync flag after reset", d & 32'h3, 32'h2);
        chk("R9 valid bit with zero year", d & 32'h4, 32'h0);
    endtask

    task automatic t_gate_idle();
        logic [31:0] d;
        bus_wr(3'd3, 32'h00ABCDEF);
        chk("R3 time write outside init", {8'd0, cal_set_time}, 32'h0);
        bus_wr(3'd4, 32'h11223344);
        chk("R3 date write outside init", cal_set_date, 32'h0);
        bus_wr(3'd2, 32'h00050003);
        bus_rd(3'd2, d);           chk("R3 divider write outside init", d, 32'h007F00FF);
        bus_wr(3'd0, 32'h2);
        chk("R3 format write outside init", {31'd0, cal_fmt12}, 32'd0);
    endtask

    task automatic t_init_entry();
        logic [31:0] d;
        int n;
        bus_wr(3'd0, 32'h1);
        bus_rd(3'd1, d);           chk("R1 ack low right after request", d & 32'h1, 32'h0);
        poll_stat(0, 1'b1, n);
        chk("R1 ack within bound", {31'd0, n <= 40}, 32'd1);
        chk("R2 hold while in init", {31'd0, cal_hold}, 32'd1);
        bus_wr(3'd2, 32'h00000002);
        bus_rd(3'd2, d);           chk("R4 first divider step", d, 32'h00000002);
        bus_wr(3'd2, 32'h00010002);
        bus_rd(3'd2, d);           chk("R4 second divider step", d, 32'h00010002);
        bus_wr(3'd3, 32'h00123000);
        chk("R3 time write in init", {8'd0, cal_set_time}, 32'h00123000);
        bus_wr(3'd4, 32'h24061500);
        chk("R3 date write in init", cal_set_date, 32'h24061500);
        bus_wr(3'd0, 32'h3);
        chk("R3 format 12h in init", {31'd0, cal_fmt12}, 32'd1);
        bus_wr(3'd0, 32'h1);
        chk("R3 format back to 24h", {31'd0, cal_fmt12}, 32'd0);
        for (int i = 0; i < 20; i++) begin
            @(negedge rtc_clk);
            if (cal_tick) chk("R2 tick while held", 32'd1, 32'd0);
        end
    endtask

    task automatic t_exit_tick();
        int n;
        bus_wr(3'd0, 32'h0);
        wait_hold(1'b0);
        chk("R6 load with release", {31'd0, cal_load}, 32'd1);
        ticks_until(n);
        chk("R5 first tick spacing", n, 32'd6);
        ticks_until(n);
        chk("R5 repeat tick spacing", n, 32'd6);
        poll_stat(0, 1'b0, n);
        chk("R1 ack drops after clear", {31'd0, n < 60}, 32'd1);
    endtask

    task automatic t_no_load();
        int n;
        int seen = 0;
        bus_wr(3'd0, 32'h1);
        poll_stat(0, 1'b1, n);
        bus_wr(3'd0, 32'h0);
        for (int i = 0; i < 12; i++) begin
            @(negedge rtc_clk);
            if (cal_load) seen++;
        end
        chk("R6 no load without new values", seen, 32'd0);
    endtask

    task automatic t_hold_phase();
        int n;
        int bad;
        for (int ph = 0; ph < 6; ph++) begin
            ticks_until(n);
            repeat (ph) @(negedge rtc_clk);
            bus_wr(3'd0, 32'h1);
            wait_hold(1'b1);
            bad = 0;
            for (int i = 0; i < 16; i++) begin
                @(negedge rtc_clk);
                if (cal_tick) bad++;
            end
            chk("R2 tick suppressed at phase", bad, 32'd0);
            bus_wr(3'd0, 32'h0);
            wait_hold(1'b0);
            ticks_until(n);
            chk("R5 full period after phased hold", n, 32'd6);
        end
    endtask

    task automatic t_refresh();
        logic [31:0] d;
        int n;
        cal_time = 24'h235959;
        cal_date = 32'h25123100;
        bus_wr(3'd1, 32'h0);
        bus_rd(3'd1, d);           chk("R7 flag cleared by zero", d & 32'h2, 32'h0);
        poll_stat(1, 1'b1, n);
        chk("R7 flag returns", {31'd0, n < 100}, 32'd1);
        bus_rd(3'd3, d);           chk("R7 shadow time", d, 32'h00235959);
        bus_rd(3'd4, d);           chk("R7 shadow date", d, 32'h25123100);
        bus_rd(3'd1, d);           chk("R9 valid with nonzero year", d & 32'h4, 32'h4);
        cal_time = 24'h010203;
        bus_wr(3'd1, 32'h2);
        repeat (80) @(negedge clk);
        bus_rd(3'd3, d);           chk("R7 writing one gives no refresh", d, 32'h00235959);
        bus_rd(3'd1, d);           chk("R7 flag stays set", d & 32'h2, 32'h2);
        cal_date = 32'h00123100;
        bus_wr(3'd1, 32'h0);
        poll_stat(1, 1'b1, n);
        bus_rd(3'd1, d);           chk("R9 valid cleared with zero year", d & 32'h4, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge rtc_clk);
        rtc_rst_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_gate_idle();
        t_init_entry();
        t_exit_tick();
        t_no_load();
        t_hold_phase();
        t_refresh();
        summary();
    end
endmodule